// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs one clause-22 management transaction on a two-wire serial management bus each time the host asks for one. The host presents a start strobe together with a direction flag, a 5-bit PHY address, a 5-bit register address and 16 bits of write data. The block then builds the whole frame on the line, clocking it with a management clock that it derives from the system clock. When the frame is over, it raises a one-cycle completion pulse. After a read, the 16 bits returned by the PHY are held on the read data port.

The data line leaves the block as three signals for an external tri-state pad: a driven value, an output enable and the sampled pad input. The management clock half-period is a parameter counted in system clocks. Its default of 50 gives a 1 µs half-period from a 50 MHz clock. The block handles one transaction at a time. A start strobe that arrives while a frame is in flight has no effect.

Top module: `mdio_frame_master`

## Requirements
- R1: Every frame opens with 32 bit periods in which `mdio_oe` is high and `mdio_out` is 1.
- R2: After the opening run, the line carries the start pattern 0 then 1, followed by the operation code: 1,0 for a read (`wr_en`=0) or 0,1 for a write (`wr_en`=1). All four bits are driven.
- R3: After the operation code come the PHY address and then the register address, 5 bits each, most significant bit first, all driven.
- R4: On a write, the block drives the turnaround bits 1 then 0, followed by the 16 write data bits, most significant bit first.
- R5: On a read, `mdio_oe` is low for the 2 turnaround periods and the 16 data periods. For each data bit, `mdio_in` is sampled in the last system clock before `mdc` rises, most significant bit first. The assembled word is on `rd_data` when `done` pulses.
- R6: `mdio_out` and `mdio_oe` change only while `mdc` is low and stay stable through each `mdc` high phase. Each `mdc` half-period lasts exactly HALF_DIV system clocks.
- R7: Every frame ends with 2 further `mdc` periods with `mdio_oe` low, which makes 66 `mdc` rising edges per transaction.
- R8: `busy` rises on the clock edge that accepts `start` and falls together with a `done` pulse that lasts one clock. A `start` asserted while `busy` is high is ignored: it neither changes the frame in flight nor adds a transaction.
- R9: During and after reset, and whenever the block is idle, `mdc`, `mdio_oe`, `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, accepted when idle |
| wr_en | input | 1 | 1 = write transaction, 0 = read transaction |
| phy_addr | input | 5 | PHY address of the request |
| reg_addr | input | 5 | Register address of the request |
| wr_data | input | 16 | Data for a write |
| rd_data | output | 16 | Data returned by the last read |
| busy | output | 1 | A transaction is in progress |
| done | output | 1 | One-clock pulse at the end of a transaction |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Value driven onto the data pad |
| mdio_oe | output | 1 | Output enable of the data pad |
| mdio_in | input | 1 | Sampled pad input |

## Verification
Writes use patterns in which the address and data fields are asymmetric: alternating bits, a single set bit at either end, and all ones against all zeros. A swapped field order or a reversed bit order therefore appears in the captured frame. Reads return responses such as 16'hA5C3 and 16'h8001, so a shift in the sampling point or a reversed bit order shows up in `rd_data`. A read whose address matches an earlier write separates the read opcode and the released turnaround from the write path. A second start strobe pulsed in the middle of a frame checks that a busy master ignores new requests.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    // Slot positions inside one frame; the wire order is behaviour.
    localparam int PRE_SLOTS  = 32;
    localparam int ST_SLOT    = 32;
    localparam int OP_SLOT    = 34;
    localparam int PHY_SLOT   = 36;
    localparam int REG_SLOT   = 41;
    localparam int TA_SLOT    = 46;
    localparam int DAT_SLOT   = 48;
    localparam int TAIL_SLOT  = 64;
    localparam int NUM_SLOTS  = 66;
    localparam int IDX_W      = 7;

    typedef enum logic {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } mgmt_op_e;

    typedef struct packed {
        mgmt_op_e    op;
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [15:0] wdata;
    } mgmt_req_t;

    typedef struct packed {
        logic drive;    // master owns the line in this slot
        logic value;    // bit placed on the line
        logic capture;  // slot carries a read data bit
    } slot_ctl_t;

    function automatic slot_ctl_t slot_decode(input logic [IDX_W-1:0] idx,
                                              input mgmt_req_t rq);
        slot_ctl_t   c;
        logic [4:0]  a_sh;
        logic [15:0] d_sh;
        c    = '0;
        a_sh = '0;
        d_sh = '0;
        if (idx < IDX_W'(ST_SLOT)) begin
            c.drive = 1'b1;
            c.value = 1'b1;
        end else if (idx < IDX_W'(OP_SLOT)) begin
            c.drive = 1'b1;
            c.value = (idx == IDX_W'(ST_SLOT + 1));
        end else if (idx < IDX_W'(PHY_SLOT)) begin
            c.drive = 1'b1;
            c.value = (rq.op == OP_WRITE) ? (idx == IDX_W'(OP_SLOT + 1))
                                          : (idx == IDX_W'(OP_SLOT));
        end else if (idx < IDX_W'(REG_SLOT)) begin
            a_sh    = rq.phy << (idx - IDX_W'(PHY_SLOT));
            c.drive = 1'b1;
            c.value = a_sh[4];
        end else if (idx < IDX_W'(TA_SLOT)) begin
            a_sh    = rq.regad << (idx - IDX_W'(REG_SLOT));
            c.drive = 1'b1;
            c.value = a_sh[4];
        end else if (idx < IDX_W'(DAT_SLOT)) begin
            c.drive = (rq.op == OP_WRITE);
            c.value = (rq.op == OP_WRITE) && (idx == IDX_W'(TA_SLOT));
        end else if (idx < IDX_W'(TAIL_SLOT)) begin
            d_sh      = rq.wdata << (idx - IDX_W'(DAT_SLOT));
            c.drive   = (rq.op == OP_WRITE);
            c.value   = (rq.op == OP_WRITE) && d_sh[15];
            c.capture = (rq.op == OP_READ);
        end
        return c;
    endfunction

endpackage

// File: rtl/mdio_half_timer.sv
module mdio_half_timer #(
    parameter int HALF_DIV = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == LAST);

    // R6: the half-period counter never passes its terminal value
    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

endmodule

// File: rtl/mdio_rx_shift.sv
module mdio_rx_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word <= '0;
        end else if (shift_en) begin
            word <= {word[W-2:0], bit_in};
        end
    end
endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
    import mdio_mgmt_pkg::*;
#(
    parameter int HALF_DIV = 50
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        wr_en,
    input  logic [4:0]  phy_addr,
    input  logic [4:0]  reg_addr,
    input  logic [15:0] wr_data,
    output logic [15:0] rd_data,
    output logic        busy,
    output logic        done,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_oe,
    input  logic        mdio_in
);
    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(NUM_SLOTS - 1);

    logic             busy_q;
    logic             done_q;
    logic             mdc_q;
    logic [IDX_W-1:0] idx_q;
    mgmt_req_t        req_q;
    slot_ctl_t        ctl;
    logic             tick;
    logic             sample_en;

    mdio_half_timer #(.HALF_DIV(HALF_DIV)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (busy_q),
        .tick (tick)
    );

    assign ctl       = slot_decode(idx_q, req_q);
    assign sample_en = busy_q && tick && !mdc_q && ctl.capture;

    mdio_rx_shift #(.W(16)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .shift_en (sample_en),
        .bit_in   (mdio_in),
        .word     (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            mdc_q  <= 1'b0;
            idx_q  <= '0;
            req_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    busy_q <= 1'b1;
                    mdc_q  <= 1'b0;
                    idx_q  <= '0;
                    req_q  <= '{op: mgmt_op_e'(wr_en), phy: phy_addr,
                               regad: reg_addr, wdata: wr_data};
                end
            end else if (tick) begin
                if (!mdc_q) begin
                    mdc_q <= 1'b1;
                end else begin
                    mdc_q <= 1'b0;
                    if (idx_q == LAST_SLOT) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
            end
        end
    end

    assign busy     = busy_q;
    assign done     = done_q;
    assign mdc      = mdc_q;
    assign mdio_oe  = busy_q && ctl.drive;
    assign mdio_out = busy_q && ctl.drive && ctl.value;

    // R1: opening run drives ones
    assert_preamble_drive_R1: assert property (@(posedge clk) disable iff (rst)
        (busy_q && idx_q < IDX_W'(PRE_SLOTS)) |-> (mdio_oe && mdio_out));

    // R6: line held through each high phase of mdc
    assert_line_stable_R6: assert property (@(posedge clk) disable iff (rst)
        (mdc_q && $past(mdc_q)) |-> ($stable(mdio_out) && $stable(mdio_oe)));

    // R5: read data is only taken while mdc is low and the line is released
    assert_sample_released_R5: assert property (@(posedge clk) disable iff (rst)
        sample_en |-> (!mdio_oe && !mdc_q));

    // R7: trailing periods release the line
    assert_tail_release_R7: assert property (@(posedge clk) disable iff (rst)
        (busy_q && idx_q >= IDX_W'(TAIL_SLOT)) |-> !mdio_oe);

    // R8: done is a single-clock pulse and coincides with busy low
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !busy_q);

    // R9: idle master leaves the bus quiet
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> (!mdc_q && !mdio_oe));

endmodule

// File: tb/sim_mdio_frame_master.sv
module sim_mdio_frame_master;
    localparam int H = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  phy_addr = '0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        busy, done, mdc, mdio_out, mdio_oe, mdio_in;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    mdio_frame_master #(.HALF_DIV(H)) u0 (
        .clk(clk), .rst(rst), .start(start), .wr_en(wr_en),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
        .rd_data(rd_data), .busy(busy), .done(done), .mdc(mdc),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    // Line capture and PHY-side responder
    int          edges = 0;
    logic        cap_out [0:127];
    logic        cap_oe  [0:127];
    logic [15:0] resp = '0;

    always @(posedge mdc) begin
        if (edges < 128) begin
            cap_out[edges] = mdio_out;
            cap_oe[edges]  = mdio_oe;
        end
        edges = edges + 1;
    end

    assign mdio_in = (edges >= 48 && edges < 64) ? resp[63 - edges] : 1'b1;

    // Half-period monitor
    logic prev_mdc = 1'b0;
    int   run_len  = 0;
    int   hp_min   = 1000000;
    int   hp_max   = 0;
    int   toggles  = 0;
    always @(posedge clk) begin
        if (mdc !== prev_mdc) begin
            if (toggles > 0) begin
                if (run_len < hp_min) hp_min = run_len;
                if (run_len > hp_max) hp_max = run_len;
            end
            toggles  = toggles + 1;
            run_len  = 1;
            prev_mdc = mdc;
        end else begin
            run_len = run_len + 1;
        end
    end

    int dones = 0;
    always @(negedge clk) if (done === 1'b1) dones = dones + 1;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_txn(input bit wr, input logic [4:0] pa, input logic [4:0] ra,
                           input logic [15:0] wd, input logic [15:0] rsp,
                           input bit poke);
        logic [65:0] gv, go;
        int          dones0;
        int          guard;
        resp    = rsp;
        edges   = 0;
        toggles = 0;
        hp_min  = 1000000;
        hp_max  = 0;
        dones0  = dones;
        @(negedge clk);
        wr_en = wr; phy_addr = pa; reg_addr = ra; wr_data = wd; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R8 busy after start", {63'd0, busy}, 64'd1);
        wr_en = ~wr; phy_addr = ~pa; reg_addr = ~ra; wr_data = ~wd;
        guard = 0;
        while (done !== 1'b1 && guard < 2000) begin
            if (poke && guard == 300) start = 1'b1;
            if (poke && guard == 302) start = 1'b0;
            @(negedge clk);
            guard++;
        end
        start = 1'b0;
        chk(guard < 2000, "R8 done within watchdog", 64'(guard), 64'd2000);
        chk(busy === 1'b0, "R8 busy low at done", {63'd0, busy}, 64'd0);
        for (int k = 0; k < 66; k++) begin
            gv[65 - k] = cap_out[k];
            go[65 - k] = cap_oe[k];
        end
        chk(gv[65:34] === 32'hFFFF_FFFF && go[65:34] === 32'hFFFF_FFFF,
            "R1 preamble", {gv[65:34], go[65:34]}, 64'hFFFF_FFFF_FFFF_FFFF);
        chk({gv[33:30], go[33:30]} === {2'b01, (wr ? 2'b01 : 2'b10), 4'hF},
            "R2 start/opcode", 64'({gv[33:30], go[33:30]}),
            64'({2'b01, (wr ? 2'b01 : 2'b10), 4'hF}));
        chk({gv[29:20], go[29:20]} === {pa, ra, 10'h3FF}, "R3 addresses",
            64'({gv[29:20], go[29:20]}), 64'({pa, ra, 10'h3FF}));
        if (wr) begin
            chk({gv[19:2], go[19:2]} === {2'b10, wd, 18'h3FFFF}, "R4 write TA/data",
                64'({gv[19:2], go[19:2]}), 64'({2'b10, wd, 18'h3FFFF}));
        end else begin
            chk(go[19:2] === 18'h0, "R5 line released", 64'(go[19:2]), 64'd0);
            chk(rd_data === rsp, "R5 read data", 64'(rd_data), 64'(rsp));
        end
        chk(go[1:0] === 2'b00 && edges == 66, "R7 tail and edge count",
            64'(edges), 64'd66);
        chk(hp_min == H && hp_max == H, "R6 half period", 64'(hp_max), 64'(H));
        repeat (40) @(negedge clk);
        chk(dones - dones0 == 1 && busy === 1'b0 && edges == 66,
            "R8 single transaction", 64'(dones - dones0), 64'd1);
    endtask

    task automatic t_reset;
        chk({mdc, mdio_oe, busy, done} === 4'b0000, "R9 reset state",
            64'({mdc, mdio_oe, busy, done}), 64'd0);
    endtask

    task automatic t_writes;
        run_txn(1'b1, 5'b10101, 5'b00001, 16'hA55A, 16'h0, 1'b0);
        run_txn(1'b1, 5'b10000, 5'b11111, 16'h8001, 16'h0, 1'b0);
        run_txn(1'b1, 5'b00001, 5'b01010, 16'h00FF, 16'h0, 1'b0);
    endtask

    task automatic t_reads;
        run_txn(1'b0, 5'b00001, 5'b01010, 16'h0, 16'hA5C3, 1'b0);
        run_txn(1'b0, 5'b11110, 5'b00011, 16'h0, 16'h8001, 1'b0);
    endtask

    task automatic t_busy_poke;
        run_txn(1'b1, 5'b01100, 5'b10011, 16'h1234, 16'h0, 1'b1);
        run_txn(1'b0, 5'b00111, 5'b11000, 16'h0, 16'h7E01, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        repeat (2) @(negedge clk);
        t_reset();
        t_writes();
        t_reads();
        t_busy_poke();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule